// File: doc/BRIEF.md
# PCI Target Address Claim Decoder

This block decides, for every bus transaction presented to a PCI target, whether the target owns the address and which of its regions is addressed. It holds the configuration state that placement depends on:
- a command word with the I/O-space and memory-space enable bits;
- a base register for a register aperture (256 KB by default);
- a base register for a raw memory aperture (256 MB by default);
- an expansion ROM base register with its own enable bit;
- a read-only class code word identifying the function as a VGA-compatible display controller.

Beyond the programmable windows, the block claims the fixed legacy VGA windows. These are the I/O range 0x3B0 to 0x3DF and the memory range 0xA0000 to 0xBFFFF. Neither needs a base register, but the matching command enable still gates them.

The surrounding bus interface presents the command and address with a valid strobe. One cycle later it reads back a hit flag and a one-hot region select that steers the transfer. Configuration software sizes the apertures in the usual way: it writes all ones to a base register and reads back the mask of implemented address bits. The block carries no bus protocol, device-select timing or data path.

Top module: `pci_claim_decoder`

## Requirements
- R1: Config dword 2 reads as 0x030000 in bits [31:8] (display controller, VGA-compatible, interface 0), with the REVISION parameter in bits [7:0]; writes to it have no effect.
- R2: Config dword 1 holds I/O enable in bit 0 and memory enable in bit 1; both reset to 0, read back as written, and all other bits read 0.
- R3: Config dword 4 is the register aperture base. Only bits [31:REG_LOG2] are stored, so writing 0xFFFFFFFF reads back 0xFFFC0000 by default. The low bits read 0, meaning 32-bit non-prefetchable memory.
- R4: Config dword 5 is the memory aperture base. Only bits [31:MEM_LOG2] are stored, so writing 0xFFFFFFFF reads back 0xF0000000 by default, with zero low bits.
- R5: Config dword 12 is the expansion ROM base. Bits [31:ROM_LOG2] are stored along with the enable in bit 0, so writing 0xFFFFFFFF reads back 0xFFFF0001 by default. Unimplemented dwords read 0, and all base registers reset to 0.
- R6: An I/O command (0x2 read, 0x3 write) to an address from 0x3B0 through 0x3DF inclusive is claimed as legacy VGA I/O, select bit 0.
- R7: A memory command to an address from 0xA0000 through 0xBFFFF inclusive is claimed as legacy VGA memory, select bit 1.
- R8: A memory command whose upper address bits equal a base register is claimed: ROM on select bit 2 (only while the ROM enable bit is 1), register aperture on bit 3, memory aperture on bit 4.
- R9: At most one select bit is set. When windows overlap, priority is legacy VGA memory, then ROM, then register aperture, then memory aperture.
- R10: No I/O claim occurs while the I/O enable is 0, and no memory claim of any kind occurs while the memory enable is 0.
- R11: The memory commands are 0x6, 0x7, 0xC, 0xE and 0xF. I/O commands match only the legacy I/O range and never a memory region. Every other command code never hits.
- R12: Hit and select are registered. They reflect the transaction sampled with bus_valid at the previous clock edge and are 0 after a cycle without bus_valid. Hit is 1 exactly when a select bit is 1. A config write in the same cycle affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Address phase present this cycle |
| bus_cmd | input | 4 | Bus command code |
| bus_addr | input | 32 | Transaction address |
| cfg_we | input | 1 | Config-space write strobe |
| cfg_idx | input | 6 | Config dword index for read and write |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_idx (combinational) |
| hit | output | 1 | Transaction claimed (registered) |
| region_sel | output | 5 | One-hot region: 0 VGA I/O, 1 VGA memory, 2 ROM, 3 register aperture, 4 memory aperture |

## Verification
The bench probes the edges of both legacy windows one address inside and one outside each end. A decoder with an off-by-one compare would claim 0x3E0 or miss 0xBFFFF. It places the memory aperture at zero and the ROM inside the register aperture to check priority. A wrong priority order shows up as two select bits at once, or as the wrong region claiming the transaction. It also sends I/O commands at aperture addresses and memory commands at legacy I/O addresses, along with non-memory command codes and cleared enable bits. Here a loose command decode would hit, and a missing enable gate would claim. Size-mask read-back catches a base register that stores bits below its size.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   localparam int NREGION     = 5;
   localparam int RS_VGA_IO   = 0;
   localparam int RS_VGA_MEM  = 1;
   localparam int RS_ROM      = 2;
   localparam int RS_REGS     = 3;
   localparam int RS_MEM      = 4;

   typedef logic [NREGION-1:0] region_t;

   localparam logic [5:0] DW_COMMAND = 6'd1;
   localparam logic [5:0] DW_CLASS   = 6'd2;
   localparam logic [5:0] DW_BAR0    = 6'd4;
   localparam logic [5:0] DW_BAR1    = 6'd5;
   localparam logic [5:0] DW_ROM     = 6'd12;

   localparam logic [23:0] CLASS_VGA = 24'h030000;

   function automatic logic cmd_is_io(input logic [3:0] c);
      return (c == 4'h2) || (c == 4'h3);
   endfunction

   function automatic logic cmd_is_mem(input logic [3:0] c);
      return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) ||
             (c == 4'hE) || (c == 4'hF);
   endfunction
endpackage

// File: rtl/pcd_bar.sv
module pcd_bar #(
   parameter int SIZE_LOG2 = 18,
   parameter bit HAS_EN    = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [31:0]           wdata,
   output logic [31:SIZE_LOG2]   base_o,
   output logic                  en_o,
   output logic [31:0]           rdata_o
);
   localparam int ZW = SIZE_LOG2 - 1;

   if (SIZE_LOG2 < 4 || SIZE_LOG2 > 30) begin : g_bad_size
      $error("pcd_bar: SIZE_LOG2 must be in 4..30");
   end

   logic [31:SIZE_LOG2] base_q;
   wire unused_low = ^wdata[SIZE_LOG2-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)  base_q <= '0;
      else if (we) base_q <= wdata[31:SIZE_LOG2];
   end

   if (HAS_EN) begin : g_en
      logic en_q;
      always_ff @(posedge clk) begin
         if (!rst_n)  en_q <= 1'b0;
         else if (we) en_q <= wdata[0];
      end
      assign en_o = en_q;
   end else begin : g_no_en
      assign en_o = 1'b1;
   end

   assign base_o  = base_q;
   assign rdata_o = {base_q, {ZW{1'b0}}, (HAS_EN ? en_o : 1'b0)};
endmodule

// File: rtl/pcd_region_decode.sv
module pcd_region_decode
   import pcd_pkg::*;
#(
   parameter int REG_LOG2 = 18,
   parameter int MEM_LOG2 = 28,
   parameter int ROM_LOG2 = 16
) (
   input  logic [3:0]          cmd,
   input  logic [31:0]         addr,
   input  logic                io_en,
   input  logic                mem_en,
   input  logic                rom_en,
   input  logic [31:REG_LOG2]  reg_base,
   input  logic [31:MEM_LOG2]  mem_base,
   input  logic [31:ROM_LOG2]  rom_base,
   output region_t             sel
);
   localparam logic [31:0] VIO_LO  = 32'h0000_03B0;
   localparam logic [31:0] VIO_HI  = 32'h0000_03DF;
   localparam logic [31:0] VMEM_LO = 32'h000A_0000;
   localparam logic [31:0] VMEM_HI = 32'h000B_FFFF;

   logic io_c, mem_c, in_vio, in_vmem, rom_m, reg_m, mem_m;

   always_comb begin
      io_c    = cmd_is_io(cmd);
      mem_c   = cmd_is_mem(cmd);
      in_vio  = (addr >= VIO_LO)  && (addr <= VIO_HI);
      in_vmem = (addr >= VMEM_LO) && (addr <= VMEM_HI);
      rom_m   = addr[31:ROM_LOG2] == rom_base;
      reg_m   = addr[31:REG_LOG2] == reg_base;
      mem_m   = addr[31:MEM_LOG2] == mem_base;
   end

   always_comb begin
      sel = '0;
      if (io_c && io_en && in_vio) begin
         sel[RS_VGA_IO] = 1'b1;
      end else if (mem_c && mem_en) begin
         if (in_vmem)              sel[RS_VGA_MEM] = 1'b1;
         else if (rom_en && rom_m) sel[RS_ROM]     = 1'b1;
         else if (reg_m)           sel[RS_REGS]    = 1'b1;
         else if (mem_m)           sel[RS_MEM]     = 1'b1;
      end
   end
endmodule

// File: rtl/pci_claim_decoder.sv
module pci_claim_decoder
   import pcd_pkg::*;
#(
   parameter int         REG_LOG2 = 18,
   parameter int         MEM_LOG2 = 28,
   parameter int         ROM_LOG2 = 16,
   parameter logic [7:0] REVISION = 8'h02
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_valid,
   input  logic [3:0]  bus_cmd,
   input  logic [31:0] bus_addr,
   input  logic        cfg_we,
   input  logic [5:0]  cfg_idx,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        hit,
   output logic [4:0]  region_sel
);
   if (ROM_LOG2 < 11) begin : g_bad_rom
      $error("pci_claim_decoder: ROM window below 2 KB");
   end
   if (REG_LOG2 < 4 || MEM_LOG2 < 4) begin : g_bad_bar
      $error("pci_claim_decoder: memory BAR below 16 bytes");
   end

   logic io_en, mem_en;
   logic [31:REG_LOG2] reg_base;
   logic [31:MEM_LOG2] mem_base;
   logic [31:ROM_LOG2] rom_base;
   logic rom_en, unused_en0, unused_en1;
   logic [31:0] bar0_rd, bar1_rd, rom_rd;
   region_t dec_sel, sel_q;
   logic hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         io_en  <= 1'b0;
         mem_en <= 1'b0;
      end else if (cfg_we && cfg_idx == DW_COMMAND) begin
         io_en  <= cfg_wdata[0];
         mem_en <= cfg_wdata[1];
      end
   end

   pcd_bar #(.SIZE_LOG2(REG_LOG2), .HAS_EN(1'b0)) u_bar_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_idx == DW_BAR0),
      .wdata(cfg_wdata), .base_o(reg_base), .en_o(unused_en0), .rdata_o(bar0_rd));

   pcd_bar #(.SIZE_LOG2(MEM_LOG2), .HAS_EN(1'b0)) u_bar_mem (
      .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_idx == DW_BAR1),
      .wdata(cfg_wdata), .base_o(mem_base), .en_o(unused_en1), .rdata_o(bar1_rd));

   pcd_bar #(.SIZE_LOG2(ROM_LOG2), .HAS_EN(1'b1)) u_bar_rom (
      .clk(clk), .rst_n(rst_n), .we(cfg_we && cfg_idx == DW_ROM),
      .wdata(cfg_wdata), .base_o(rom_base), .en_o(rom_en), .rdata_o(rom_rd));

   always_comb begin
      case (cfg_idx)
         DW_COMMAND: cfg_rdata = {30'd0, mem_en, io_en};
         DW_CLASS:   cfg_rdata = {CLASS_VGA, REVISION};
         DW_BAR0:    cfg_rdata = bar0_rd;
         DW_BAR1:    cfg_rdata = bar1_rd;
         DW_ROM:     cfg_rdata = rom_rd;
         default:    cfg_rdata = 32'd0;
      endcase
   end

   pcd_region_decode #(.REG_LOG2(REG_LOG2), .MEM_LOG2(MEM_LOG2), .ROM_LOG2(ROM_LOG2)) u_dec (
      .cmd(bus_cmd), .addr(bus_addr), .io_en(io_en), .mem_en(mem_en), .rom_en(rom_en),
      .reg_base(reg_base), .mem_base(mem_base), .rom_base(rom_base), .sel(dec_sel));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         hit_q <= 1'b0;
      end else begin
         sel_q <= bus_valid ? dec_sel : '0;
         hit_q <= bus_valid && (dec_sel != '0);
      end
   end

   assign hit        = hit_q;
   assign region_sel = sel_q;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(region_sel)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> (!hit && region_sel == '0)); // R12
   AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (region_sel != '0)); // R12
   AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !io_en) |=> !region_sel[RS_VGA_IO]); // R10
   AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !mem_en) |=> (region_sel[4:1] == 4'd0)); // R10
   AST_ROM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !rom_en) |=> !region_sel[RS_ROM]); // R8
   AST_CMD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !cmd_is_io(bus_cmd) && !cmd_is_mem(bus_cmd)) |=> !hit); // R11
endmodule

// File: tb/pci_claim_decoder_test.sv
module pci_claim_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic [3:0]  bus_cmd = 4'h0;
   logic [31:0] bus_addr = 32'h0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_idx = 6'd0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic        hit;
   logic [4:0]  region_sel;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference model state
   bit          m_io = 0, m_mem = 0;
   logic [31:0] m_bar0 = 0, m_bar1 = 0, m_rom = 0;
   logic [4:0]  exp_sel = 0;

   always #4 clk = ~clk;

   pci_claim_decoder uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hit(hit),
      .region_sel(region_sel));

   function automatic logic [31:0] ref_read(input logic [5:0] idx);
      case (idx)
         6'd1:    return {30'd0, m_mem, m_io};
         6'd2:    return 32'h0300_0002;
         6'd4:    return m_bar0;
         6'd5:    return m_bar1;
         6'd12:   return m_rom;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [4:0] ref_dec(input logic [3:0] c, input logic [31:0] a);
      bit io = (c == 4'h2) || (c == 4'h3);
      bit mm = c inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
      if (io && m_io && a >= 32'h3B0 && a <= 32'h3DF) return 5'b00001;
      if (mm && m_mem) begin
         if (a >= 32'hA0000 && a <= 32'hBFFFF) return 5'b00010;
         if (m_rom[0] && (a & 32'hFFFF0000) == (m_rom & 32'hFFFF0000)) return 5'b00100;
         if ((a & 32'hFFFC0000) == m_bar0) return 5'b01000;
         if ((a & 32'hF0000000) == m_bar1) return 5'b10000;
      end
      return 5'b00000;
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check read data, advance model at posedge, compare at next negedge.
   task automatic cyc(input string req, input logic v, input logic [3:0] c, input logic [31:0] a,
                      input logic we, input logic [5:0] idx, input logic [31:0] wd);
      bus_valid = v; bus_cmd = c; bus_addr = a;
      cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
      #1;
      check(req, "cfg_rdata", cfg_rdata, ref_read(idx));
      @(posedge clk);
      exp_sel = v ? ref_dec(c, a) : 5'b0;
      if (we) begin
         case (idx)
            6'd1:  begin m_io = wd[0]; m_mem = wd[1]; end
            6'd4:  m_bar0 = wd & 32'hFFFC0000;
            6'd5:  m_bar1 = wd & 32'hF0000000;
            6'd12: m_rom  = wd & 32'hFFFF0001;
            default: ;
         endcase
      end
      @(negedge clk);
      check(req, "region_sel", {27'd0, region_sel}, {27'd0, exp_sel});
      check(req, "hit", {31'd0, hit}, {31'd0, (exp_sel != 0)});
   endtask

   task automatic wr(input string req, input logic [5:0] idx, input logic [31:0] wd);
      cyc(req, 1'b0, 4'h0, 32'h0, 1'b1, idx, wd);
   endtask

   task automatic rd(input string req, input logic [5:0] idx);
      cyc(req, 1'b0, 4'h0, 32'h0, 1'b0, idx, 32'h0);
   endtask

   task automatic acc(input string req, input logic [3:0] c, input logic [31:0] a);
      cyc(req, 1'b1, c, a, 1'b0, 6'd0, 32'h0);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13-style reset state covered by R2 and R5 reads
      rd("R2", 6'd1);
      rd("R5", 6'd4); rd("R5", 6'd5); rd("R5", 6'd12); rd("R5", 6'd7);
      // R1 class code, write ignored
      rd("R1", 6'd2);
      wr("R1", 6'd2, 32'hFFFFFFFF);
      rd("R1", 6'd2);
      // R10 nothing claimed with enables clear
      acc("R10", 4'h2, 32'h3C0);
      acc("R10", 4'h6, 32'hA0000);
      acc("R10", 4'h6, 32'h00000100);
      // R3 R4 R5 size probes
      wr("R3", 6'd4, 32'hFFFFFFFF); rd("R3", 6'd4);
      wr("R4", 6'd5, 32'hFFFFFFFF); rd("R4", 6'd5);
      wr("R5", 6'd12, 32'hFFFFFFFF); rd("R5", 6'd12);
      wr("R2", 6'd1, 32'hFFFFFFFF); rd("R2", 6'd1);
      wr("R2", 6'd1, 32'h00000001); rd("R2", 6'd1);
      // R10 io only: memory claims blocked
      acc("R10", 4'h6, 32'hB0000);
      acc("R6", 4'h3, 32'h3B0);
      // program apertures
      wr("R3", 6'd4, 32'hE0000000);
      wr("R4", 6'd5, 32'h40000000);
      wr("R5", 6'd12, 32'hE0100001);
      wr("R2", 6'd3, 32'h0);
      wr("R2", 6'd1, 32'h00000003);
      // R6 legacy I/O edges
      acc("R6", 4'h2, 32'h3AF); acc("R6", 4'h2, 32'h3B0);
      acc("R6", 4'h3, 32'h3DF); acc("R6", 4'h3, 32'h3E0);
      // R7 legacy memory edges
      acc("R7", 4'h6, 32'h9FFFF); acc("R7", 4'h7, 32'hA0000);
      acc("R7", 4'hC, 32'hBFFFF); acc("R7", 4'hE, 32'hC0000);
      // R8 apertures
      acc("R8", 4'h6, 32'hE0000010); acc("R8", 4'h7, 32'hE003FFFC);
      acc("R8", 4'h6, 32'hE0040000); acc("R8", 4'hF, 32'h4FFFFFF0);
      acc("R8", 4'h6, 32'hE0100020); acc("R8", 4'h6, 32'hE0110000);
      wr("R8", 6'd12, 32'hE0100000);
      acc("R8", 4'h6, 32'hE0100020);
      // R9 overlap: ROM inside register aperture, memory aperture at zero
      wr("R9", 6'd12, 32'hE0010001);
      acc("R9", 4'h6, 32'hE0010040); acc("R9", 4'h6, 32'hE0020000);
      wr("R9", 6'd5, 32'h00000000);
      acc("R9", 4'h6, 32'hA0000); acc("R9", 4'h6, 32'hC0000);
      // R11 command classes
      acc("R11", 4'hA, 32'h3C0); acc("R11", 4'h2, 32'hE0000000);
      acc("R11", 4'h6, 32'h3C0); acc("R11", 4'h0, 32'hA0000);
      acc("R11", 4'hB, 32'hE0000000); acc("R11", 4'h3, 32'hA0000);
      // R12 write and access in the same cycle: old state decodes
      cyc("R12", 1'b1, 4'h6, 32'h0000_1000, 1'b1, 6'd1, 32'h0);
      acc("R12", 4'h6, 32'h0000_1000);
      wr("R12", 6'd1, 32'h3);
      // R12 mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [3:0]  c;
         logic [31:0] a;
         int k = $urandom_range(0, 9);
         c = 4'($urandom_range(0, 15));
         case (k)
            0: a = 32'h3A0 + 32'($urandom_range(0, 80));
            1: a = 32'h9FFF0 + 32'($urandom_range(0, 32'h20040));
            2: a = (m_bar0 & 32'hFFFC0000) + 32'($urandom_range(0, 32'h50000));
            3: a = (m_rom & 32'hFFFF0000) + 32'($urandom_range(0, 32'h18000));
            4: a = {4'($urandom_range(0, 15)), 28'($urandom)};
            default: a = $urandom;
         endcase
         if ($urandom_range(0, 19) == 0) begin
            int w = $urandom_range(0, 3);
            logic [5:0] idx = (w == 0) ? 6'd1 : (w == 1) ? 6'd4 : (w == 2) ? 6'd5 : 6'd12;
            cyc("R12", 1'($urandom_range(0, 1)), c, a, 1'b1, idx, $urandom);
         end else begin
            cyc("R12", 1'($urandom_range(0, 3) != 0), c, a, 1'b0,
                6'($urandom_range(0, 13)), 32'h0);
         end
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule